// File: doc/BRIEF.md
# Linked descriptor DMA fetch engine

This block is a single DMA channel that moves data between memory and a device over one simple memory master port. Software starts it with a pulse and a configuration word. With the link bit of that word clear, the channel runs one transfer taken from its programmed source, destination and byte count. With the link bit set, the channel instead reads a chain of eight-word descriptors from memory. It starts at a programmed pointer and follows each descriptor's own next pointer, so a chain can close on itself to form a ring.

Each descriptor is gated by a valid flag in its first word. The engine runs a valid descriptor and then writes that first word back with the flag cleared, so producer software can refill the slot. The walk ends on an invalid slot or after a descriptor that asks for an end interrupt. Every data beat is one read and one write. Each beat waits for the device request, and the acknowledge marks the beat's access on the device side.

Top module: `lddma_engine`

## Requirements
- R1: After reset, busy, err, end_irq, mem_req and dack are all low.
- R2: With config bit 31 clear at start, the engine moves ceil(count / 2^S) beats, where S is config bits 14:12. Each beat is one read at the source address followed by one write of that word at the destination. The source advances by 2^S bytes and the destination by 2^D bytes, where D is config bits 18:16.
- R3: Config bit 20 holds the source address fixed and config bit 21 holds the destination address fixed for the whole transfer.
- R4: With config bit 31 set at start, the engine reads an eight-word descriptor at the link address. The word offsets are 0 header, 4 source, 8 destination, 12 byte count, 16 config, 20 interval, 24 extension and 28 next link. The engine then runs the transfer those words describe.
- R5: A fetched header with bit 0 clear stops the engine. No data moves, busy falls, no end interrupt fires, and memory is not written.
- R6: When a descriptor finishes, its header word is written back with bit 0 cleared and all other bits kept, before anything else is fetched.
- R7: A descriptor whose config bit 24 is set is followed by a fetch at its next-link address, with no interrupt. A descriptor whose bit 24 is clear ends the walk with a one-cycle end_irq pulse, in the first cycle that busy is low.
- R8: A zero byte count finishes the transfer without any data access. In link mode the header is still written back.
- R9: Each beat waits for dreq to be high. dack pulses for one cycle per beat: on the completion of the read when config bit 3 is clear, or on the completion of the write when config bit 3 is set.
- R10: A response with mem_err stops the engine. err rises, busy falls, no end_irq fires, and err stays set until the next start.
- R11: Once raised, mem_req holds its address, direction and write data steady until mem_ready.
- R12: In single-transfer mode, end_irq pulses once at the end when config bit 24 is clear and stays low when it is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle start pulse, taken only while idle |
| prog_cfg | input | 32 | Start configuration word (bit 31 selects link mode) |
| prog_link | input | AW | First descriptor address in link mode |
| prog_src | input | AW | Source byte address in single mode |
| prog_dst | input | AW | Destination byte address in single mode |
| prog_count | input | CW | Byte count in single mode |
| dreq | input | 1 | Device request, gates every beat |
| dack | output | 1 | Device acknowledge, one cycle per beat |
| busy | output | 1 | Channel enabled |
| err | output | 1 | Sticky bus error status |
| end_irq | output | 1 | End-of-transfer pulse |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Byte address of the access |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ready |
| mem_ready | input | 1 | Access completes this cycle |
| mem_err | input | 1 | Error response, valid with mem_ready |

## Verification
A fetch index that slips shows up as wrong destination contents or a header left valid, within a few dozen cycles of the chain's end. A count or stride register that is off shows up as a wrong number of dack pulses, or as words written outside the expected region, once the transfer settles. A wrong walk state, such as failing to stop on an invalid slot or on an error, is caught when busy is still high after the stimulus, or when end_irq fires when it should not. These show at the ports within a few cycles of the offending bus response.

// File: rtl/lddma_pkg.sv
package lddma_pkg;
   localparam int HDR_VALID  = 0;
   localparam int CFG_LINK   = 31;
   localparam int CFG_NOIRQ  = 24;
   localparam int CFG_DFIX   = 21;
   localparam int CFG_SFIX   = 20;
   localparam int CFG_DSZ_LO = 16;
   localparam int CFG_SSZ_LO = 12;
   localparam int CFG_TODEV  = 3;

   localparam int DESC_WORDS = 8;
   localparam int IDX_W      = $clog2(DESC_WORDS);

   localparam logic [IDX_W-1:0] WI_HDR  = 3'd0;
   localparam logic [IDX_W-1:0] WI_SRC  = 3'd1;
   localparam logic [IDX_W-1:0] WI_DST  = 3'd2;
   localparam logic [IDX_W-1:0] WI_CNT  = 3'd3;
   localparam logic [IDX_W-1:0] WI_CFG  = 3'd4;
   localparam logic [IDX_W-1:0] WI_LINK = 3'd7;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_FETCH,
      ST_REQ,
      ST_READ,
      ST_WRITE,
      ST_BACK,
      ST_FIN
   } st_e;
endpackage

// File: rtl/lddma_step.sv
module lddma_step #(
   parameter int AW = 32
) (
   input  logic [AW-1:0] addr,
   input  logic [2:0]    size_log2,
   input  logic          hold,
   output logic [AW-1:0] next
);
   logic [AW-1:0] stride;

   assign stride = AW'(1) << size_log2;
   assign next   = hold ? addr : addr + stride;
endmodule

// File: rtl/lddma_desc_regs.sv
module lddma_desc_regs
   import lddma_pkg::*;
#(
   parameter int AW = 32,
   parameter int CW = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_prog,
   input  logic [31:0]      prog_cfg,
   input  logic [AW-1:0]    prog_src,
   input  logic [AW-1:0]    prog_dst,
   input  logic [CW-1:0]    prog_cnt,
   input  logic             cap_en,
   input  logic [IDX_W-1:0] cap_idx,
   input  logic [31:0]      cap_data,
   input  logic             adv,
   input  logic [AW-1:0]    src_nxt,
   input  logic [AW-1:0]    dst_nxt,
   input  logic [CW-1:0]    cnt_nxt,
   output logic [31:0]      hdr,
   output logic [AW-1:0]    src,
   output logic [AW-1:0]    dst,
   output logic [CW-1:0]    cnt,
   output logic [31:0]      cfg,
   output logic [AW-1:0]    link
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hdr  <= '0;
         src  <= '0;
         dst  <= '0;
         cnt  <= '0;
         cfg  <= '0;
         link <= '0;
      end else if (load_prog) begin
         hdr <= '0;
         src <= prog_src;
         dst <= prog_dst;
         cnt <= prog_cnt;
         cfg <= prog_cfg;
      end else if (cap_en) begin
         case (cap_idx)
            WI_HDR:  hdr  <= cap_data;
            WI_SRC:  src  <= cap_data[AW-1:0];
            WI_DST:  dst  <= cap_data[AW-1:0];
            WI_CNT:  cnt  <= cap_data[CW-1:0];
            WI_CFG:  cfg  <= cap_data;
            WI_LINK: link <= cap_data[AW-1:0];
            default: ;
         endcase
      end else if (adv) begin
         src <= src_nxt;
         dst <= dst_nxt;
         cnt <= cnt_nxt;
      end
   end

   // R2: every beat shrinks the remaining count
   p_cnt_drop_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      adv |=> (cnt < $past(cnt)));
endmodule

// File: rtl/lddma_engine.sv
module lddma_engine
   import lddma_pkg::*;
#(
   parameter int AW = 32,
   parameter int CW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [31:0]   prog_cfg,
   input  logic [AW-1:0] prog_link,
   input  logic [AW-1:0] prog_src,
   input  logic [AW-1:0] prog_dst,
   input  logic [CW-1:0] prog_count,
   input  logic          dreq,
   output logic          dack,
   output logic          busy,
   output logic          err,
   output logic          end_irq,
   output logic          mem_req,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [31:0]   mem_wdata,
   input  logic [31:0]   mem_rdata,
   input  logic          mem_ready,
   input  logic          mem_err
);
   localparam int WORD_SHIFT = 2;

   generate
      if (AW < 8 || AW > 32) begin : g_bad_aw
         $error("lddma_engine: AW must lie in 8..32");
      end
      if (CW < 4 || CW > 32) begin : g_bad_cw
         $error("lddma_engine: CW must lie in 4..32");
      end
   endgenerate

   st_e              st;
   logic [IDX_W-1:0] idx;
   logic [AW-1:0]    dbase;
   logic [31:0]      dbuf;
   logic             link_mode;

   logic [31:0]      hdr;
   logic [31:0]      cfg;
   logic [AW-1:0]    src, dst, link;
   logic [AW-1:0]    src_nxt, dst_nxt;
   logic [CW-1:0]    cnt, cnt_nxt, unit;
   logic             ack, last_beat;
   logic             load_prog, cap_en, adv;

   assign ack       = mem_req && mem_ready;
   assign unit      = CW'(1) << cfg[CFG_SSZ_LO +: 3];
   assign last_beat = (cnt <= unit);
   assign cnt_nxt   = last_beat ? '0 : cnt - unit;

   assign load_prog = (st == ST_IDLE) && start && !prog_cfg[CFG_LINK];
   assign cap_en    = (st == ST_FETCH) && ack && !mem_err;
   assign adv       = (st == ST_WRITE) && ack && !mem_err;

   lddma_desc_regs #(.AW(AW), .CW(CW)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_prog(load_prog),
      .prog_cfg (prog_cfg),
      .prog_src (prog_src),
      .prog_dst (prog_dst),
      .prog_cnt (prog_count),
      .cap_en   (cap_en),
      .cap_idx  (idx),
      .cap_data (mem_rdata),
      .adv      (adv),
      .src_nxt  (src_nxt),
      .dst_nxt  (dst_nxt),
      .cnt_nxt  (cnt_nxt),
      .hdr      (hdr),
      .src      (src),
      .dst      (dst),
      .cnt      (cnt),
      .cfg      (cfg),
      .link     (link)
   );

   lddma_step #(.AW(AW)) u_src_step (
      .addr     (src),
      .size_log2(cfg[CFG_SSZ_LO +: 3]),
      .hold     (cfg[CFG_SFIX]),
      .next     (src_nxt)
   );

   lddma_step #(.AW(AW)) u_dst_step (
      .addr     (dst),
      .size_log2(cfg[CFG_DSZ_LO +: 3]),
      .hold     (cfg[CFG_DFIX]),
      .next     (dst_nxt)
   );

   // bus outputs
   always_comb begin
      mem_req   = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = '0;
      mem_wdata = '0;
      case (st)
         ST_FETCH: begin
            mem_req  = 1'b1;
            mem_addr = dbase + (AW'(idx) << WORD_SHIFT);
         end
         ST_READ: begin
            mem_req  = 1'b1;
            mem_addr = src;
         end
         ST_WRITE: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = dst;
            mem_wdata = dbuf;
         end
         ST_BACK: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = dbase;
            mem_wdata = {hdr[31:1], 1'b0};
         end
         default: ;
      endcase
   end

   assign busy = (st != ST_IDLE);
   assign dack = ack && !mem_err &&
                 (((st == ST_READ) && !cfg[CFG_TODEV]) ||
                  ((st == ST_WRITE) && cfg[CFG_TODEV]));

   // walk sequencer
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         idx       <= '0;
         dbase     <= '0;
         dbuf      <= '0;
         link_mode <= 1'b0;
         err       <= 1'b0;
         end_irq   <= 1'b0;
      end else begin
         end_irq <= 1'b0;
         case (st)
            ST_IDLE: begin
               if (start) begin
                  err <= 1'b0;
                  if (prog_cfg[CFG_LINK]) begin
                     link_mode <= 1'b1;
                     dbase     <= prog_link;
                     idx       <= '0;
                     st        <= ST_FETCH;
                  end else begin
                     link_mode <= 1'b0;
                     st        <= (prog_count == '0) ? ST_FIN : ST_REQ;
                  end
               end
            end
            ST_FETCH: begin
               if (ack) begin
                  if (mem_err) begin
                     err <= 1'b1;
                     st  <= ST_IDLE;
                  end else if (idx == WI_HDR && !mem_rdata[HDR_VALID]) begin
                     st <= ST_IDLE;
                  end else if (idx == WI_LINK) begin
                     st <= (cnt == '0) ? ST_BACK : ST_REQ;
                  end else begin
                     idx <= idx + 1'b1;
                  end
               end
            end
            ST_REQ: begin
               if (dreq) st <= ST_READ;
            end
            ST_READ: begin
               if (ack) begin
                  if (mem_err) begin
                     err <= 1'b1;
                     st  <= ST_IDLE;
                  end else begin
                     dbuf <= mem_rdata;
                     st   <= ST_WRITE;
                  end
               end
            end
            ST_WRITE: begin
               if (ack) begin
                  if (mem_err) begin
                     err <= 1'b1;
                     st  <= ST_IDLE;
                  end else if (last_beat) begin
                     st <= link_mode ? ST_BACK : ST_FIN;
                  end else begin
                     st <= ST_REQ;
                  end
               end
            end
            ST_BACK: begin
               if (ack) begin
                  if (mem_err) begin
                     err <= 1'b1;
                     st  <= ST_IDLE;
                  end else begin
                     st <= ST_FIN;
                  end
               end
            end
            ST_FIN: begin
               end_irq <= !cfg[CFG_NOIRQ];
               if (link_mode && cfg[CFG_NOIRQ]) begin
                  dbase <= link;
                  idx   <= '0;
                  st    <= ST_FETCH;
               end else begin
                  st <= ST_IDLE;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   logic unused_bits;
   assign unused_bits = ^{cfg[31:25], cfg[23:22], cfg[19], cfg[15], cfg[11:4],
                          cfg[2:0], hdr[0]};

   // R11: a pending access keeps its address, direction and data
   p_req_hold_r11 : assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) &&
                                   $stable(mem_we) && $stable(mem_wdata)));

   // R1: an idle channel drives no bus or device activity
   p_idle_quiet_r1 : assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!mem_req && !dack));

   // R5: an invalid header ends the walk at once without interrupt
   p_invalid_stop_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      ((st == ST_FETCH) && (idx == WI_HDR) && ack && !mem_err && !mem_rdata[HDR_VALID])
      |=> (!busy && !end_irq));

   // R10: an error response stops the channel with status set
   p_err_stop_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      (ack && mem_err) |=> (err && !busy && !end_irq));

   // R7: the end pulse only comes with the channel stopped
   p_irq_idle_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      end_irq |-> !busy);

   // R9: one acknowledge cycle per beat
   p_dack_pulse_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      dack |=> !dack);
endmodule

// File: tb/lddma_engine_bench.sv
module lddma_engine_bench;
   localparam int AW = 32;
   localparam int CW = 32;

   typedef struct packed {
      logic [31:0] cfg;
      logic [15:0] src;
      logic [15:0] dst;
      logic [15:0] cnt;
   } vec_t;

   // single-mode vectors: cfg, source, destination, byte count
   localparam vec_t VECS [6] = '{
      '{32'h0002_2000, 16'h0100, 16'h0200, 16'd16},   // R2 plain, 4 beats
      '{32'h0002_2000, 16'h0140, 16'h0240, 16'd10},   // R2 partial last beat
      '{32'h0012_2000, 16'h0180, 16'h0280, 16'd12},   // R3 fixed source
      '{32'h0022_2008, 16'h01C0, 16'h02C0, 16'd8},    // R3 fixed destination, to device
      '{32'h0002_3000, 16'h0100, 16'h0300, 16'd16},   // R2 unequal strides
      '{32'h0102_2000, 16'h0120, 16'h0320, 16'd4}     // R12 interrupt masked
   };

   logic          clk = 1'b0;
   logic          rst_n;
   logic          start;
   logic [31:0]   prog_cfg;
   logic [AW-1:0] prog_link, prog_src, prog_dst;
   logic [CW-1:0] prog_count;
   logic          dreq;
   logic          dack, busy, err, end_irq;
   logic          mem_req, mem_we;
   logic [AW-1:0] mem_addr;
   logic [31:0]   mem_wdata, mem_rdata;
   logic          mem_ready, mem_err;

   always #2 clk = ~clk;

   lddma_engine #(.AW(AW), .CW(CW)) u_lddma_engine (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .prog_cfg  (prog_cfg),
      .prog_link (prog_link),
      .prog_src  (prog_src),
      .prog_dst  (prog_dst),
      .prog_count(prog_count),
      .dreq      (dreq),
      .dack      (dack),
      .busy      (busy),
      .err       (err),
      .end_irq   (end_irq),
      .mem_req   (mem_req),
      .mem_we    (mem_we),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .mem_rdata (mem_rdata),
      .mem_ready (mem_ready),
      .mem_err   (mem_err)
   );

   logic [31:0] mem    [256];
   logic [31:0] shadow [256];
   logic        err_on;
   logic [9:0]  err_addr;

   // memory model: answers one cycle after a request
   always @(posedge clk) begin
      if (!rst_n) begin
         mem_ready <= 1'b0;
         mem_err   <= 1'b0;
         mem_rdata <= '0;
      end else if (mem_req && !mem_ready) begin
         mem_ready <= 1'b1;
         mem_err   <= err_on && (mem_addr[9:0] == err_addr);
         mem_rdata <= mem[mem_addr[9:2]];
         if (mem_we && !(err_on && (mem_addr[9:0] == err_addr)))
            mem[mem_addr[9:2]] <= mem_wdata;
      end else begin
         mem_ready <= 1'b0;
         mem_err   <= 1'b0;
      end
   end

   int       dack_n = 0;
   int       irq_n = 0;
   int       hold_bad = 0;
   logic     dack_we_last = 1'b0;
   logic     prev_pend = 1'b0;
   logic [AW-1:0] prev_addr = '0;

   always @(negedge clk) begin
      if (dack) begin
         dack_n       = dack_n + 1;
         dack_we_last = mem_we;
      end
      if (end_irq) irq_n = irq_n + 1;
      if (prev_pend && (!mem_req || mem_addr != prev_addr)) hold_bad = hold_bad + 1;
      prev_pend = mem_req && !mem_ready;
      prev_addr = mem_addr;
   end

   int checks = 0;
   int errors = 0;

   function automatic logic [31:0] pat(input int i);
      return 32'hC0DE_0000 ^ (i * 32'h0001_0003);
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic settle();
      @(negedge clk);
      #1;
   endtask

   task automatic fill_mem();
      for (int i = 0; i < 256; i++) mem[i] = pat(i);
   endtask

   task automatic snap();
      for (int i = 0; i < 256; i++) shadow[i] = mem[i];
   endtask

   function automatic int diff_count();
      int n = 0;
      for (int i = 0; i < 256; i++) if (mem[i] !== shadow[i]) n++;
      return n;
   endfunction

   task automatic put_desc(input int base, input logic [31:0] hdr, input logic [31:0] src,
                           input logic [31:0] dst, input logic [31:0] cnt,
                           input logic [31:0] cfg, input logic [31:0] nxt);
      mem[(base >> 2) + 0] = hdr;
      mem[(base >> 2) + 1] = src;
      mem[(base >> 2) + 2] = dst;
      mem[(base >> 2) + 3] = cnt;
      mem[(base >> 2) + 4] = cfg;
      mem[(base >> 2) + 5] = 32'h0;
      mem[(base >> 2) + 6] = 32'h0;
      mem[(base >> 2) + 7] = nxt;
   endtask

   // expected effect of one transfer, from R2/R3
   task automatic model_xfer(input logic [31:0] cfg, input int src, input int dst, input int cnt);
      int unit  = 1 << cfg[14:12];
      int sstep = cfg[20] ? 0 : unit;
      int dstep = cfg[21] ? 0 : (1 << cfg[18:16]);
      int beats = (cnt + unit - 1) / unit;
      for (int k = 0; k < beats; k++)
         shadow[((dst + k * dstep) >> 2) & 255] = mem[((src + k * sstep) >> 2) & 255];
   endtask

   task automatic pulse_start(input logic [31:0] cfg, input logic [31:0] lnk,
                              input logic [31:0] src, input logic [31:0] dst,
                              input logic [31:0] cnt);
      prog_cfg   = cfg;
      prog_link  = lnk;
      prog_src   = src;
      prog_dst   = dst;
      prog_count = cnt;
      start      = 1'b1;
      settle();
      start      = 1'b0;
   endtask

   task automatic wait_idle();
      int n = 0;
      while (busy && n < 3000) begin
         settle();
         n++;
      end
      if (busy) begin
         errors++;
         $display("FAIL watchdog: channel still busy actual=1 expected=0");
      end
      settle();
      settle();
   endtask

   task automatic run(input logic [31:0] cfg, input logic [31:0] lnk,
                      input logic [31:0] src, input logic [31:0] dst,
                      input logic [31:0] cnt);
      pulse_start(cfg, lnk, src, dst, cnt);
      wait_idle();
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: run did not finish actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int d0, i0, beats, unit;
      rst_n = 1'b0; start = 1'b0; dreq = 1'b1; err_on = 1'b0; err_addr = '0;
      prog_cfg = '0; prog_link = '0; prog_src = '0; prog_dst = '0; prog_count = '0;
      fill_mem();
      repeat (4) settle();
      // R1 reset state
      chk("R1 busy", 32'(busy), 32'd0);
      chk("R1 err", 32'(err), 32'd0);
      chk("R1 end_irq", 32'(end_irq), 32'd0);
      chk("R1 mem_req", 32'(mem_req), 32'd0);
      chk("R1 dack", 32'(dack), 32'd0);
      rst_n = 1'b1;
      settle();

      // table walk: single-transfer mode
      foreach (VECS[v]) begin
         fill_mem();
         snap();
         model_xfer(VECS[v].cfg, int'(VECS[v].src), int'(VECS[v].dst), int'(VECS[v].cnt));
         unit  = 1 << VECS[v].cfg[14:12];
         beats = (int'(VECS[v].cnt) + unit - 1) / unit;
         d0 = dack_n; i0 = irq_n;
         run(VECS[v].cfg, 32'h0, 32'(VECS[v].src), 32'(VECS[v].dst), 32'(VECS[v].cnt));
         chk("R2 R3 memory mismatches", 32'(diff_count()), 32'd0);
         chk("R9 dack pulses", 32'(dack_n - d0), 32'(beats));
         chk("R9 dack side", 32'(dack_we_last), 32'(VECS[v].cfg[3]));
         chk("R12 end_irq count", 32'(irq_n - i0), VECS[v].cfg[24] ? 32'd0 : 32'd1);
         chk("R2 err", 32'(err), 32'd0);
      end

      // R4 R6 R7: three-slot chain walked out of address order
      fill_mem();
      put_desc(32'h000, 32'h5A5A_0001, 32'h100, 32'h200, 32'd8,  32'h8102_2000, 32'h040);
      put_desc(32'h040, 32'h1234_0081, 32'h110, 32'h210, 32'd4,  32'h0102_2008, 32'h020);
      put_desc(32'h020, 32'h0F0F_0001, 32'h120, 32'h220, 32'd4,  32'h0002_2000, 32'h000);
      snap();
      model_xfer(32'h0002_2000, 32'h100, 32'h200, 8);
      model_xfer(32'h0002_2000, 32'h110, 32'h210, 4);
      model_xfer(32'h0002_2000, 32'h120, 32'h220, 4);
      shadow[0]  = 32'h5A5A_0000;
      shadow[16] = 32'h1234_0080;
      shadow[8]  = 32'h0F0F_0000;
      d0 = dack_n; i0 = irq_n;
      run(32'h8000_0000, 32'h000, 32'h0, 32'h0, 32'h0);
      chk("R4 R7 chain memory mismatches", 32'(diff_count()), 32'd0);
      chk("R6 header 0 cleared", mem[0], 32'h5A5A_0000);
      chk("R6 header 1 cleared", mem[16], 32'h1234_0080);
      chk("R7 end_irq once", 32'(irq_n - i0), 32'd1);
      chk("R4 dack pulses", 32'(dack_n - d0), 32'd4);
      chk("R7 stopped", 32'(busy), 32'd0);

      // R5: walk stops on an invalid slot
      fill_mem();
      put_desc(32'h060, 32'h0000_0010, 32'h100, 32'h200, 32'd8, 32'h0002_2000, 32'h000);
      snap();
      d0 = dack_n; i0 = irq_n;
      run(32'h8000_0000, 32'h060, 32'h0, 32'h0, 32'h0);
      chk("R5 memory untouched", 32'(diff_count()), 32'd0);
      chk("R5 no dack", 32'(dack_n - d0), 32'd0);
      chk("R5 no end_irq", 32'(irq_n - i0), 32'd0);
      chk("R5 busy", 32'(busy), 32'd0);

      // R5 R7: continuing slot followed by an invalid one, no interrupt
      fill_mem();
      put_desc(32'h0A0, 32'h0000_0001, 32'h130, 32'h230, 32'd4, 32'h0102_2000, 32'h0C0);
      put_desc(32'h0C0, 32'h0000_0000, 32'h140, 32'h240, 32'd4, 32'h0002_2000, 32'h000);
      snap();
      model_xfer(32'h0002_2000, 32'h130, 32'h230, 4);
      shadow[40] = 32'h0;
      i0 = irq_n;
      run(32'h8000_0000, 32'h0A0, 32'h0, 32'h0, 32'h0);
      chk("R5 R7 ring stop mismatches", 32'(diff_count()), 32'd0);
      chk("R7 no end_irq on masked slot", 32'(irq_n - i0), 32'd0);

      // R8: zero count in link mode and in single mode
      fill_mem();
      put_desc(32'h080, 32'h0000_0003, 32'h100, 32'h200, 32'd0, 32'h0002_2000, 32'h000);
      snap();
      shadow[32] = 32'h0000_0002;
      d0 = dack_n; i0 = irq_n;
      run(32'h8000_0000, 32'h080, 32'h0, 32'h0, 32'h0);
      chk("R8 link zero mismatches", 32'(diff_count()), 32'd0);
      chk("R8 link zero dack", 32'(dack_n - d0), 32'd0);
      chk("R8 link zero end_irq", 32'(irq_n - i0), 32'd1);
      snap();
      d0 = dack_n; i0 = irq_n;
      run(32'h0002_2000, 32'h0, 32'h100, 32'h200, 32'd0);
      chk("R8 single zero mismatches", 32'(diff_count()), 32'd0);
      chk("R8 single zero dack", 32'(dack_n - d0), 32'd0);
      chk("R8 single zero end_irq", 32'(irq_n - i0), 32'd1);

      // R9: beats wait for the device request
      fill_mem();
      dreq = 1'b0;
      d0 = dack_n;
      pulse_start(32'h0002_2000, 32'h0, 32'h100, 32'h200, 32'd8);
      repeat (30) settle();
      chk("R9 held busy", 32'(busy), 32'd1);
      chk("R9 no write without dreq", mem[128], pat(128));
      chk("R9 no dack without dreq", 32'(dack_n - d0), 32'd0);
      dreq = 1'b1;
      wait_idle();
      chk("R9 data after dreq", mem[128], pat(64));
      chk("R9 second beat", mem[129], pat(65));

      // R10: error on the second read
      fill_mem();
      err_on = 1'b1; err_addr = 10'h104;
      i0 = irq_n;
      run(32'h0002_2000, 32'h0, 32'h100, 32'h200, 32'd16);
      chk("R10 err set", 32'(err), 32'd1);
      chk("R10 stopped", 32'(busy), 32'd0);
      chk("R10 no end_irq", 32'(irq_n - i0), 32'd0);
      chk("R10 first beat kept", mem[128], pat(64));
      chk("R10 later beat absent", mem[129], pat(129));
      err_on = 1'b0;
      run(32'h0002_2000, 32'h0, 32'h100, 32'h200, 32'd4);
      chk("R10 err cleared by start", 32'(err), 32'd0);

      // R11: request stability seen at the ports over the whole run
      chk("R11 request hold violations", 32'(hold_bad), 32'd0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule